// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the timing and control side of a successive-approximation converter. It picks one of several events to start a conversion. Those events are a software command, two timer-overflow strobes, an external convert-start pin, and a software start issued to a sibling converter. In low-power mode it inserts a tracking phase of fixed length before converting. It divides the system clock into a SAR clock that times both phases. When a conversion ends it captures the result word that the analog core presents. It also keeps a sticky completion flag and a sticky window-compare flag.

Software reaches the block through a simple write port with four addresses:
- Address 0 is control: bit 0 enable, bit 1 low-power track, bits 4:2 start source, bit 5 go, bit 6 clear-done, bit 7 clear-window.
- Address 1 is the SAR clock period field, in bits 4:0.
- Address 2 is the upper window threshold.
- Address 3 is the lower window threshold.

The result bus has no valid/ready pair. It is sampled in the final cycle of a conversion, and the analog core cannot apply back-pressure, so every control and status pin is a plain level or strobe. The data width `RES_W` must be at least 8 and at least `DIV_W`.

Top module: `adc_start_seq`

## Requirements
- R1: After reset these outputs are all 0: busy, conversion-active, tracking, complete flag, window flag and result. The enable bit is also 0.
- R2: Control bits 4:2 select the start source:
  - 000: a control write with go=1.
  - 001: `tmr3_ovf`.
  - 010: a rising edge of `ext_start_pin`.
  - 011: `tmr2_ovf`.
  - 1xx: `sib_sw_start`.
  Strobes from sources that are not selected have no effect.
- R3: The SAR clock period is P+1 system clocks, where P is the value in register 1 bits 4:0. P is sampled when a conversion starts. In normal mode the result is latched and the complete flag is set at the 10(P+1)-th rising edge after the start edge.
- R4: In low-power mode with a source other than 010, a start first raises `trk_hold` for 3(P+1) cycles with `conv_active` low. The 10-SAR-clock conversion follows.
- R5: `ext_start_pin` passes through a two-flop synchronizer, so a conversion starts two edges after the pin is first sampled high. In low-power mode with source 010, `trk_hold` is high while the idle block sees the synchronized pin low, and no fixed tracking phase is inserted.
- R6: `busy` is high from the start edge until the edge that latches the result. A go bit written while the source field is not 000, or a go bit of 0, starts nothing.
- R7: The result and the complete flag update on the same edge. The flag stays set until a control write with bit 6 set. If a clear and a completion fall on the same edge, the flag is set.
- R8: The window flag sets at completion when the result is greater than the upper threshold or less than the lower threshold; equality is not a match. The flag stays set until a control write with bit 7 set, and bit 7 leaves the complete flag untouched.
- R9: While the enable bit is 0, no source starts a conversion.
- R10: Start events that arrive while busy are ignored, and the running conversion keeps its original end time.
- R11: In normal mode, `trk_hold` is high whenever the block is idle and enabled. `conv_active` is high exactly during the conversion phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | RES_W | Register write data |
| tmr3_ovf | input | 1 | Timer overflow strobe, source 001 |
| tmr2_ovf | input | 1 | Timer overflow strobe, source 011 |
| ext_start_pin | input | 1 | Asynchronous convert-start pin |
| sib_sw_start | input | 1 | Software start of the sibling converter |
| res_data | input | RES_W | Result from the analog core |
| trk_hold | output | 1 | Sample capacitor tracking |
| conv_active | output | 1 | Conversion phase in progress |
| busy | output | 1 | Tracking or conversion under way |
| done_flag | output | 1 | Sticky conversion-complete flag |
| win_flag | output | 1 | Sticky window-match flag |
| result | output | RES_W | Latched conversion result |

## Verification
The coincidence that matters is a software clear of the complete flag landing on the same edge that ends a conversion and sets the flag. The bench counts cycles from the start edge and issues the clearing control write so that it is sampled on exactly the finishing edge. It then expects the flag to read 1, and a later clear to bring it to 0. A second coincidence is a new go command arriving mid-conversion. This is judged by the completion time staying at the original 10(P+1) edges and by no second conversion following.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_t;

  // register addresses
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_SARDIV = 2'd1;
  localparam logic [1:0] A_WHI    = 2'd2;
  localparam logic [1:0] A_WLO    = 2'd3;

  // control register bit positions
  localparam int B_EN       = 0;
  localparam int B_LP       = 1;
  localparam int B_SRC_LO   = 2;
  localparam int B_GO       = 5;
  localparam int B_CLR_DONE = 6;
  localparam int B_CLR_WIN  = 7;

  // start source codes (1xx = sibling start)
  localparam logic [2:0] SRC_SW  = 3'b000;
  localparam logic [2:0] SRC_T3  = 3'b001;
  localparam logic [2:0] SRC_PIN = 3'b010;
  localparam logic [2:0] SRC_T2  = 3'b011;

endpackage

// File: rtl/adc_sar_div.sv
module adc_sar_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] per_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_q;

  // period is captured while idle so a write never disturbs a running conversion
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      per_q <= per_i;
    end else if (cnt_q == per_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == per_q);

  // R3
  div_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q <= per_q));

endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [2:0] src_i,
  input  logic       sw_go_i,
  input  logic       t3_i,
  input  logic       t2_i,
  input  logic       pin_i,
  input  logic       sib_i,
  output logic       start_o,
  output logic       pin_lvl_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   evt;

  // R5 synchronizer chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_lvl_o = sync_q[SYNC_STAGES-1];
  assign rise      = pin_lvl_o && !prev_q;

  // R2 source decode
  always_comb begin
    case (src_i)
      SRC_SW:  evt = 1'b0;
      SRC_T3:  evt = t3_i;
      SRC_PIN: evt = rise;
      SRC_T2:  evt = t2_i;
      default: evt = sib_i;
    endcase
  end

  // R9: sw_go_i is already qualified by the written enable bit
  assign start_o = sw_go_i || (en_i && evt);

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CONV_TICKS  = 10,
  parameter int TRACK_TICKS = 3,
  parameter int WIN_OUTSIDE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             lp_i,
  input  logic             pin_src_i,
  input  logic             pin_lvl_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [RES_W-1:0] whi_i,
  input  logic [RES_W-1:0] wlo_i,
  input  logic             clr_done_i,
  input  logic             clr_win_i,
  output logic             run_o,
  output logic             busy_o,
  output logic             trk_o,
  output logic             conv_o,
  output logic             done_o,
  output logic             win_o,
  output logic [RES_W-1:0] result_o
);

  localparam int PH_MAX = (CONV_TICKS > TRACK_TICKS) ? CONV_TICKS : TRACK_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  seq_state_t       state_q, state_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [RES_W-1:0] result_q;
  logic             done_q, win_q;
  logic             finish;
  logic             match;

  // R8 window match form chosen by parameter
  if (WIN_OUTSIDE != 0) begin : g_win_out
    assign match = (res_i > whi_i) || (res_i < wlo_i);
  end else begin : g_win_in
    assign match = (res_i <= whi_i) && (res_i >= wlo_i);
  end

  assign finish = (state_q == ST_CONV) && tick_i && (ph_q == PH_W'(CONV_TICKS - 1));

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    case (state_q)
      ST_IDLE: begin
        // R10: starts only accepted here
        if (start_i) begin
          ph_d    = '0;
          state_d = (lp_i && !pin_src_i) ? ST_TRACK : ST_CONV;  // R4
        end
      end
      ST_TRACK: begin
        if (tick_i) begin
          if (ph_q == PH_W'(TRACK_TICKS - 1)) begin
            ph_d    = '0;
            state_d = ST_CONV;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (tick_i) begin
          if (finish) begin
            ph_d    = '0;
            state_d = ST_IDLE;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ph_q     <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      win_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      if (finish) result_q <= res_i;
      // R7: a completion beats a clear on the same edge
      if (finish)          done_q <= 1'b1;
      else if (clr_done_i) done_q <= 1'b0;
      if (finish && match) win_q <= 1'b1;
      else if (clr_win_i)  win_q <= 1'b0;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign run_o    = busy_o;
  assign conv_o   = (state_q == ST_CONV);
  assign trk_o    = (state_q == ST_TRACK) ||
                    ((state_q == ST_IDLE) && en_i &&
                     (!lp_i || (pin_src_i && !pin_lvl_i)));
  assign done_o   = done_q;
  assign win_o    = win_q;
  assign result_o = result_q;

  // R7
  done_from_conv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(state_q == ST_CONV));

  // R7
  end_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_q);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> $stable(result_q));

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int DIV_W       = 5,
  parameter int CONV_TICKS  = 10,
  parameter int TRACK_TICKS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_OUTSIDE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [RES_W-1:0] wr_data,
  input  logic             tmr3_ovf,
  input  logic             tmr2_ovf,
  input  logic             ext_start_pin,
  input  logic             sib_sw_start,
  input  logic [RES_W-1:0] res_data,
  output logic             trk_hold,
  output logic             conv_active,
  output logic             busy,
  output logic             done_flag,
  output logic             win_flag,
  output logic [RES_W-1:0] result
);

  logic             en_q, lp_q;
  logic [2:0]       src_q;
  logic [DIV_W-1:0] per_q;
  logic [RES_W-1:0] whi_q, wlo_q;
  logic             ctrl_wr, sw_go, clr_done, clr_win;
  logic             start, pin_lvl, tick, run, busy_w;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  // R6: go only counts with source 000 and enable written together
  assign sw_go    = ctrl_wr && wr_data[B_GO] && wr_data[B_EN] &&
                    (wr_data[B_SRC_LO +: 3] == SRC_SW);
  assign clr_done = ctrl_wr && wr_data[B_CLR_DONE];
  assign clr_win  = ctrl_wr && wr_data[B_CLR_WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      lp_q  <= 1'b0;
      src_q <= SRC_SW;
      per_q <= '0;
      whi_q <= '0;
      wlo_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en_q  <= wr_data[B_EN];
          lp_q  <= wr_data[B_LP];
          src_q <= wr_data[B_SRC_LO +: 3];
        end
        A_SARDIV: per_q <= wr_data[DIV_W-1:0];
        A_WHI:    whi_q <= wr_data;
        default:  wlo_q <= wr_data;
      endcase
    end
  end

  adc_start_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_q),
    .src_i     (src_q),
    .sw_go_i   (sw_go),
    .t3_i      (tmr3_ovf),
    .t2_i      (tmr2_ovf),
    .pin_i     (ext_start_pin),
    .sib_i     (sib_sw_start),
    .start_o   (start),
    .pin_lvl_o (pin_lvl)
  );

  adc_sar_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .per_i  (per_q),
    .tick_o (tick)
  );

  adc_conv_fsm #(
    .RES_W       (RES_W),
    .CONV_TICKS  (CONV_TICKS),
    .TRACK_TICKS (TRACK_TICKS),
    .WIN_OUTSIDE (WIN_OUTSIDE)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .en_i       (en_q),
    .lp_i       (lp_q),
    .pin_src_i  (src_q == SRC_PIN),
    .pin_lvl_i  (pin_lvl),
    .tick_i     (tick),
    .res_i      (res_data),
    .whi_i      (whi_q),
    .wlo_i      (wlo_q),
    .clr_done_i (clr_done),
    .clr_win_i  (clr_win),
    .run_o      (run),
    .busy_o     (busy_w),
    .trk_o      (trk_hold),
    .conv_o     (conv_active),
    .done_o     (done_flag),
    .win_o      (win_flag),
    .result_o   (result)
  );

  assign busy = busy_w;

  // R9
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !ctrl_wr && !busy_w) |=> !busy_w);

endmodule

// File: tb/sim_adc_start_seq.sv
`timescale 1ns/1ps
module sim_adc_start_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        tmr3_ovf = 1'b0, tmr2_ovf = 1'b0, ext_start_pin = 1'b0, sib_sw_start = 1'b0;
  logic [11:0] res_data = '0;
  logic        trk_hold, conv_active, busy, done_flag, win_flag;
  logic [11:0] result;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  adc_start_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf), .ext_start_pin(ext_start_pin),
    .sib_sw_start(sib_sw_start), .res_data(res_data), .trk_hold(trk_hold),
    .conv_active(conv_active), .busy(busy), .done_flag(done_flag),
    .win_flag(win_flag), .result(result)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic        lp;
    logic [4:0]  per;
    logic [11:0] res;
    logic [11:0] whi;
    logic [11:0] wlo;
    logic        win;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{3'd0, 1'b0, 5'd0,  12'h123, 12'h200, 12'h100, 1'b0},
    '{3'd1, 1'b0, 5'd1,  12'h300, 12'h200, 12'h100, 1'b1},
    '{3'd3, 1'b1, 5'd2,  12'h050, 12'h200, 12'h100, 1'b1},
    '{3'd2, 1'b0, 5'd0,  12'h100, 12'h100, 12'h100, 1'b0},
    '{3'd4, 1'b1, 5'd1,  12'h201, 12'h200, 12'h000, 1'b1},
    '{3'd2, 1'b1, 5'd3,  12'h0FF, 12'hFFF, 12'h000, 1'b0},
    '{3'd7, 1'b0, 5'd31, 12'hFFF, 12'hFFE, 12'h000, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cw(input logic en, input logic lp, input logic [2:0] src,
                                     input logic go, input logic cd, input logic cwn);
    return {4'b0, cwn, cd, go, src, lp, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drop();
    wr_en = 1'b0; tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; sib_sw_start = 1'b0;
  endtask

  // called at a negedge; the trigger is sampled at the next posedge
  task automatic fire(input logic [2:0] src, input logic lp);
    if (src == 3'd0) begin
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1'b1, lp, 3'd0, 1'b1, 1'b0, 1'b0);
    end else if (src == 3'd1) tmr3_ovf = 1'b1;
    else if (src == 3'd2) ext_start_pin = 1'b1;
    else if (src == 3'd3) tmr2_ovf = 1'b1;
    else sib_sw_start = 1'b1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); drop();
      if (done_flag || cyc >= 4000) break;
    end
  endtask

  function automatic int exp_cyc(input logic [2:0] src, input logic lp, input int per);
    int n;
    n = 10 * (per + 1);
    if (lp && src != 3'd2) n += 3 * (per + 1);
    n += 1;
    if (src == 3'd2) n += 2;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done_flag, 0);
    chk("R1 win", win_flag, 0);
    chk("R1 result", result, 0);
    chk("R1 conv_active", conv_active, 0);
    chk("R1 trk_hold", trk_hold, 0);

    // table of vectors: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 7; i++) begin
      wr(2'd1, {7'd0, VT[i].per});
      wr(2'd2, VT[i].whi);
      wr(2'd3, VT[i].wlo);
      res_data = VT[i].res;
      wr(2'd0, cw(1'b1, VT[i].lp, VT[i].src, 1'b0, 1'b1, 1'b1));
      repeat (4) @(negedge clk);
      chk($sformatf("R7 done cleared v%0d", i), done_flag, 0);
      chk($sformatf("R8 win cleared v%0d", i), win_flag, 0);
      fire(VT[i].src, VT[i].lp);
      wait_done(cyc);
      chk($sformatf("R3 latency v%0d", i), cyc, exp_cyc(VT[i].src, VT[i].lp, VT[i].per));
      chk($sformatf("R7 result v%0d", i), result, VT[i].res);
      chk($sformatf("R8 win v%0d", i), win_flag, VT[i].win);
      chk($sformatf("R6 busy low v%0d", i), busy, 0);
      ext_start_pin = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R9 enable off ignores starts
    wr(2'd1, 12'd0);
    wr(2'd0, cw(1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1));
    chk("R9 go while disabled", busy, 0);
    wr(2'd0, cw(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0));
    tmr3_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 timer while disabled", busy, 0);
    chk("R9 no done", done_flag, 0);

    // R2 unselected sources, R6 go with wrong source
    wr(2'd0, cw(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0));
    tmr2_ovf = 1'b1; sib_sw_start = 1'b1; @(negedge clk); drop();
    @(negedge clk);
    chk("R2 t2/sib ignored with src 001", busy, 0);
    ext_start_pin = 1'b1; repeat (5) @(negedge clk);
    chk("R2 pin ignored with src 001", busy, 0);
    ext_start_pin = 1'b0; repeat (3) @(negedge clk);
    wr(2'd0, cw(1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    chk("R6 go ignored with src 001", busy, 0);
    wr(2'd0, cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk("R6 go=0 no start", busy, 0);

    // R10 restart ignored while busy
    res_data = 12'h5A5;
    wr(2'd0, cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
    fire(3'd0, 1'b0);
    cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); drop();
      if (cyc == 4) begin
        chk("R6 busy mid conversion", busy, 1);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
      end
      if (done_flag || cyc >= 4000) break;
    end
    chk("R10 original end time", cyc, 11);
    repeat (12) @(negedge clk);
    chk("R10 no second conversion", busy, 0);

    // R7 clear and completion on the same edge
    res_data = 12'hABC;
    wr(2'd0, cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
    fire(3'd0, 1'b0);
    cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); drop();
      if (cyc == 10) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      end
      if (cyc >= 11) break;
    end
    chk("R7 set wins over clear", done_flag, 1);
    chk("R7 result at collision", result, 12'hABC);
    wr(2'd0, cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0));
    chk("R7 later clear", done_flag, 0);

    // R8 window clear leaves done alone
    wr(2'd2, 12'h100); wr(2'd3, 12'h000);
    res_data = 12'h200;
    @(negedge clk);
    fire(3'd0, 1'b0);
    wait_done(cyc);
    chk("R8 match above upper", win_flag, 1);
    wr(2'd0, cw(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1));
    chk("R8 win cleared", win_flag, 0);
    chk("R8 done untouched", done_flag, 1);

    // R4 low-power track phase, R11 outputs
    wr(2'd0, cw(1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
    chk("R4 idle lp not tracking", trk_hold, 0);
    fire(3'd0, 1'b1);
    cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); drop();
      if (cyc == 1) begin
        chk("R4 tracking first", trk_hold, 1);
        chk("R4 not converting while tracking", conv_active, 0);
      end
      if (cyc == 4) begin
        chk("R11 conv_active after track", conv_active, 1);
        chk("R4 track ended", trk_hold, 0);
      end
      if (done_flag || cyc >= 4000) break;
    end
    chk("R4 latency", cyc, 14);
    chk("R11 conv_active low at end", conv_active, 0);

    // R5 low-power pin source tracks while pin low
    wr(2'd0, cw(1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1));
    ext_start_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 tracking while pin low", trk_hold, 1);
    fire(3'd2, 1'b1);
    wait_done(cyc);
    chk("R5 pin latency", cyc, 13);
    ext_start_pin = 1'b0;
    repeat (3) @(negedge clk);

    // R11 normal mode idle tracking
    wr(2'd0, cw(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0));
    chk("R11 idle normal tracking", trk_hold, 1);
    chk("R11 idle not converting", conv_active, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule